// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into its final page table entry by descending a four-level table tree held in memory. A start request carries the virtual address and the frame number of the top-level table. At each level the walker picks a 9-bit index out of the virtual address, forms the address of the 8-byte entry inside the current table, issues one read and waits for the data. An entry whose present bit is set supplies the frame of the next table. The walk ends either with the lowest-level entry or with a not-present fault.

Reads use a simple handshake. The walker raises a request strobe for one cycle with the entry address. It keeps the address on the bus until a response-valid pulse returns 64 bits of entry data, which may take any number of cycles. The result is a one-cycle done pulse, or a one-cycle fault pulse together with the level at which the walk stopped. A translation cache and the fault handling sit outside this block.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy_o, mem_req_o, done_o and fault_o are all 0.
- R2: The read for level k (k = 0 is the top level) targets {table_frame, index_k, 3'b000}. index_0 is vaddr_i[47:39], index_1 is [38:30], index_2 is [29:21] and index_3 is [20:12]. The level-0 table frame is root_ppn_i, sampled with the start request.
- R3: For levels 0 to 2, an entry with bit 0 (present) set gives the frame of the next-level table in its bits [51:12].
- R4: An entry at level 0, 1 or 2 with bit 0 clear ends the walk. It pulses fault_o, sets fault_level_o to that level (0 to 2), and issues no further read.
- R5: A leaf (level 3) entry with bit 0 clear pulses fault_o with fault_level_o = 3, and leaf_o holds that entry.
- R6: A walk with all four entries present issues exactly four reads, then pulses done_o. leaf_o holds the full 64-bit leaf entry, flag bits included.
- R7: Each level takes one request cycle plus the cycles until the response is sampled. With a response L cycles after the request (L >= 1), the result pulse appears n*(L+1) clock edges after the edge that samples start_i, where n is the number of reads. The first request is raised in the cycle after that edge.
- R8: A start_i pulse while busy_o is 1 is ignored. The running walk keeps its address and root, and no extra walk follows.
- R9: done_o and fault_o are single-cycle pulses and never high together. mem_req_o is high for one cycle per read, and mem_addr_o holds its value in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a walk (sampled when idle) |
| vaddr_i | input | 48 | Virtual address to translate |
| root_ppn_i | input | 40 | Frame number of the top-level table |
| mem_req_o | output | 1 | Read request strobe, one cycle per read |
| mem_addr_o | output | 52 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data valid pulse |
| mem_rdata_i | input | 64 | Returned table entry |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk finished with a present leaf (pulse) |
| fault_o | output | 1 | Walk stopped on a clear present bit (pulse) |
| fault_level_o | output | 2 | Level at which the fault was taken |
| leaf_o | output | 64 | Last leaf entry read |

## Verification
The first read request is due one cycle after start_i is sampled. Each level then adds one request cycle plus the response latency, so a result pulse is due n*(L+1) edges after the start edge. The bench's memory model answers each request after a chosen latency L and logs every read address. Each test counts falling edges from start to the done or fault pulse and compares the count with n*(L+1)+1, so an early or late result is caught as well as a wrong one. The pulse width and the absence of further reads are checked on the falling edges that follow the result.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int unsigned VA_W      = 48;
  localparam int unsigned PA_W      = 52;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned IDX_W     = 9;
  localparam int unsigned LEVELS    = 4;
  localparam int unsigned ENT_W     = 64;
  localparam int unsigned ENT_SHIFT = 3;   // 8-byte entries
  localparam int unsigned LVL_W     = $clog2(LEVELS);
  localparam int unsigned PPN_W     = PA_W - OFF_W;
  localparam int unsigned VPN_W     = VA_W - OFF_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_st_e;
endpackage

// File: rtl/pt_idx_sel.sv
module pt_idx_sel #(
  parameter int unsigned VPN_W  = pt_walk_pkg::VPN_W,
  parameter int unsigned IDX_W  = pt_walk_pkg::IDX_W,
  parameter int unsigned LEVELS = pt_walk_pkg::LEVELS,
  parameter int unsigned LVL_W  = pt_walk_pkg::LVL_W
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_tab [LEVELS];

  // level 0 takes the top slice of the page number
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign idx_tab[g] = vpn_i[(LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign idx_o = idx_tab[lvl_i];
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int unsigned PPN_W     = pt_walk_pkg::PPN_W,
  parameter int unsigned IDX_W     = pt_walk_pkg::IDX_W,
  parameter int unsigned ENT_SHIFT = pt_walk_pkg::ENT_SHIFT,
  localparam int unsigned ADDR_W   = PPN_W + IDX_W + ENT_SHIFT
) (
  input  logic [PPN_W-1:0]  base_ppn_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  // a whole table fills one page, so base + idx*8 needs no adder
  assign addr_o = {base_ppn_i, idx_i, {ENT_SHIFT{1'b0}}};
endmodule

// File: rtl/pt_entry_dec.sv
module pt_entry_dec #(
  parameter int unsigned ENT_W = pt_walk_pkg::ENT_W,
  parameter int unsigned PA_W  = pt_walk_pkg::PA_W,
  parameter int unsigned OFF_W = pt_walk_pkg::OFF_W,
  localparam int unsigned PPN_W = PA_W - OFF_W
) (
  input  logic [ENT_W-1:0] entry_i,
  output logic             present_o,
  output logic [PPN_W-1:0] next_ppn_o
);
  assign present_o  = entry_i[0];
  assign next_ppn_o = entry_i[PA_W-1:OFF_W];

  logic unused_bits;
  assign unused_bits = ^{entry_i[ENT_W-1:PA_W], entry_i[OFF_W-1:1]};
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
#(
  parameter int unsigned LEVELS = pt_walk_pkg::LEVELS,
  parameter int unsigned PPN_W  = pt_walk_pkg::PPN_W,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  input  logic             rvalid_i,
  input  logic             present_i,
  input  logic [PPN_W-1:0] next_ppn_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic [PPN_W-1:0] base_ppn_o,
  output logic             load_va_o,
  output logic             leaf_we_o,
  output logic             req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [LVL_W-1:0] fault_lvl_o
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_st_e         st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PPN_W-1:0] base_q;
  logic             done_q, fault_q;
  logic [LVL_W-1:0] flvl_q;
  logic             resp_ok;

  assign resp_ok = (st_q == ST_WAIT) && rvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_REQ;
            lvl_q  <= '0;
            base_q <= root_ppn_i;
          end
        end
        ST_REQ: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (resp_ok) begin
            if (!present_i) begin
              fault_q <= 1'b1;
              flvl_q  <= lvl_q;
              st_q    <= ST_IDLE;
            end else if (lvl_q == LAST_LVL) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              base_q <= next_ppn_i;
              lvl_q  <= lvl_q + LVL_W'(1);
              st_q   <= ST_REQ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign lvl_o       = lvl_q;
  assign base_ppn_o  = base_q;
  assign load_va_o   = (st_q == ST_IDLE) && start_i;
  assign leaf_we_o   = resp_ok && (lvl_q == LAST_LVL);
  assign req_o       = (st_q == ST_REQ);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign fault_lvl_o = flvl_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned VA_W   = pt_walk_pkg::VA_W,
  parameter int unsigned PA_W   = pt_walk_pkg::PA_W,
  parameter int unsigned OFF_W  = pt_walk_pkg::OFF_W,
  parameter int unsigned IDX_W  = pt_walk_pkg::IDX_W,
  parameter int unsigned LEVELS = pt_walk_pkg::LEVELS,
  parameter int unsigned ENT_W  = pt_walk_pkg::ENT_W,
  localparam int unsigned PPN_W = PA_W - OFF_W,
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [ENT_W-1:0] mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [LVL_W-1:0] fault_level_o,
  output logic [ENT_W-1:0] leaf_o
);
  logic [VPN_W-1:0] vpn_q;
  logic [ENT_W-1:0] leaf_q;
  logic [LVL_W-1:0] lvl;
  logic [PPN_W-1:0] base_ppn, next_ppn;
  logic [IDX_W-1:0] idx;
  logic             load_va, leaf_we, present;

  pt_walk_ctrl #(.LEVELS(LEVELS), .PPN_W(PPN_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .root_ppn_i  (root_ppn_i),
    .rvalid_i    (mem_rvalid_i),
    .present_i   (present),
    .next_ppn_i  (next_ppn),
    .lvl_o       (lvl),
    .base_ppn_o  (base_ppn),
    .load_va_o   (load_va),
    .leaf_we_o   (leaf_we),
    .req_o       (mem_req_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .fault_lvl_o (fault_level_o)
  );

  pt_idx_sel #(.VPN_W(VPN_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) i_idx (
    .vpn_i (vpn_q),
    .lvl_i (lvl),
    .idx_o (idx)
  );

  pt_addr_gen #(.PPN_W(PPN_W), .IDX_W(IDX_W), .ENT_SHIFT(OFF_W - IDX_W)) i_addr (
    .base_ppn_i (base_ppn),
    .idx_i      (idx),
    .addr_o     (mem_addr_o)
  );

  pt_entry_dec #(.ENT_W(ENT_W), .PA_W(PA_W), .OFF_W(OFF_W)) i_dec (
    .entry_i    (mem_rdata_i),
    .present_o  (present),
    .next_ppn_o (next_ppn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_q  <= '0;
      leaf_q <= '0;
    end else begin
      if (load_va) vpn_q  <= vaddr_i[VA_W-1:OFF_W];
      if (leaf_we) leaf_q <= mem_rdata_i;
    end
  end

  assign leaf_o = leaf_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned PA_W  = 52,
  parameter int unsigned ENT_W = 64,
  parameter int unsigned LVL_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             mem_req_o,
  input logic [PA_W-1:0]  mem_addr_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             fault_o,
  input logic [LVL_W-1:0] fault_level_o,
  input logic [ENT_W-1:0] leaf_o
);
  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fault_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);
  p_req_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> $stable(mem_addr_o));
  p_addr_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000));
  p_first_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && mem_req_o));
  p_req_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  p_leaf_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && (fault_level_o == LVL_W'(3))) |-> !leaf_o[0]);
  p_done_leaf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> leaf_o[0]);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .ENT_W(ENT_W), .LVL_W(LVL_W)) i_pt_walker_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .fault_o       (fault_o),
  .fault_level_o (fault_level_o),
  .leaf_o        (leaf_o)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [47:0] vaddr_i = '0;
  logic [39:0] root_ppn_i = '0;
  logic        mem_req_o;
  logic [51:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        busy_o, done_o, fault_o;
  logic [1:0]  fault_level_o;
  logic [63:0] leaf_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pt_walker i_pt_walker (
    .clk_i, .rst_ni, .start_i, .vaddr_i, .root_ppn_i,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .busy_o, .done_o, .fault_o, .fault_level_o, .leaf_o
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [63:0] mem_q [logic [51:0]];
  logic [51:0] addr_log [8];
  int          rd_cnt = 0;
  int          lat_g = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: answers each request lat_g cycles later
  initial begin
    @(negedge clk_i);
    forever begin
      if (mem_req_o) begin
        logic [51:0] a;
        a = mem_addr_o;
        if (rd_cnt < 8) addr_log[rd_cnt] = a;
        rd_cnt++;
        repeat (lat_g) @(negedge clk_i);
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem_q.exists(a) ? mem_q[a] : 64'h0;
        @(negedge clk_i);
        mem_rvalid_i = 1'b0;
        mem_rdata_i  = '0;
      end else begin
        @(negedge clk_i);
      end
    end
  end

  function automatic logic [8:0] idx_of(input logic [47:0] va, input int k);
    return va[47 - 9*k -: 9];
  endfunction

  function automatic logic [51:0] ent_addr(input logic [39:0] tbl, input logic [8:0] idx);
    return {tbl, idx, 3'b000};
  endfunction

  // fault_lvl 0..2: upper entry not present at that level; 3: none
  task automatic run_walk(input string name, input logic [47:0] va,
                          input logic [39:0] root, input logic [39:0] t1,
                          input logic [39:0] t2, input logic [39:0] t3,
                          input logic [63:0] leaf, input int fault_lvl,
                          input int lat, input bit inject);
    logic [39:0] tbl [4];
    int n, cnt, rd_end;
    bit exp_fault;
    logic [1:0] exp_lvl;
    tbl[0] = root; tbl[1] = t1; tbl[2] = t2; tbl[3] = t3;
    mem_q.delete();
    for (int k = 0; k < 4; k++) begin
      if (k < 3) begin
        mem_q[ent_addr(tbl[k], idx_of(va, k))] =
          {12'h0, tbl[k+1], 11'h2A5, (k == fault_lvl) ? 1'b0 : 1'b1};
      end else begin
        mem_q[ent_addr(tbl[k], idx_of(va, k))] = leaf;
      end
    end
    n         = (fault_lvl < 3) ? fault_lvl + 1 : 4;
    exp_fault = (fault_lvl < 3) || !leaf[0];
    exp_lvl   = (fault_lvl < 3) ? 2'(fault_lvl) : 2'd3;
    lat_g  = lat;
    rd_cnt = 0;
    @(negedge clk_i);
    start_i = 1'b1; vaddr_i = va; root_ppn_i = root;
    cnt = 0;
    while (!(done_o || fault_o) && cnt < 500) begin
      @(negedge clk_i);
      cnt++;
      if (cnt == 1) start_i = 1'b0;
      if (inject && cnt == 3) begin
        start_i = 1'b1; vaddr_i = ~va; root_ppn_i = ~root;
      end
      if (inject && cnt == 4) start_i = 1'b0;
    end
    chk(cnt == n*(lat+1)+1, "R7", {name, " result cycle"}, 64'(cnt), 64'(n*(lat+1)+1));
    chk(rd_cnt == n, exp_fault ? "R4" : "R6", {name, " read count"}, 64'(rd_cnt), 64'(n));
    for (int k = 0; k < n && k < 8; k++)
      chk(addr_log[k] == ent_addr(tbl[k], idx_of(va, k)), (k == 0) ? "R2" : "R3",
          {name, " read address"}, 64'(addr_log[k]), 64'(ent_addr(tbl[k], idx_of(va, k))));
    chk(fault_o == exp_fault && done_o == !exp_fault, exp_fault ? "R4" : "R6",
        {name, " fault/done"}, {62'h0, fault_o, done_o}, {62'h0, exp_fault, !exp_fault});
    if (exp_fault)
      chk(fault_level_o == exp_lvl, (fault_lvl < 3) ? "R4" : "R5",
          {name, " fault level"}, 64'(fault_level_o), 64'(exp_lvl));
    if (fault_lvl >= 3)
      chk(leaf_o == leaf, exp_fault ? "R5" : "R6", {name, " leaf"}, leaf_o, leaf);
    rd_end = rd_cnt;
    @(negedge clk_i);
    chk(!done_o && !fault_o, "R9", {name, " pulse width"}, {62'h0, done_o, fault_o}, 64'h0);
    repeat (4) @(negedge clk_i);
    chk(!busy_o && rd_cnt == rd_end, inject ? "R8" : "R4",
        {name, " idle after result"}, 64'(rd_cnt), 64'(rd_end));
  endtask

  task automatic t_reset;
    chk(!busy_o && !mem_req_o && !done_o && !fault_o, "R1", "reset outputs",
        {60'h0, busy_o, mem_req_o, done_o, fault_o}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    run_walk("full lat1", 48'h7F12_3456_7ABC, 40'h00_0000_0100, 40'h00_0000_0A01,
             40'h00_0012_3402, 40'h80_0000_0003, 64'h8000_0ABC_DEF0_1007, 3, 1, 0);
    run_walk("full lat3", 48'hFFFF_FFFF_F123, 40'hFF_FFFF_F000, 40'h00_0000_0001,
             40'h55_5555_5555, 40'hAA_AAAA_AAAA, 64'hFFF0_0001_2345_6063, 3, 3, 0);
    run_walk("fault l0", 48'h0000_0000_1000, 40'h00_0000_0200, 40'h00_0000_0300,
             40'h00_0000_0400, 40'h00_0000_0500, 64'h1, 0, 2, 0);
    run_walk("fault l1", 48'h4020_1008_0000, 40'h00_0000_0210, 40'h00_0000_0310,
             40'h00_0000_0410, 40'h00_0000_0510, 64'h1, 1, 1, 0);
    run_walk("fault l2", 48'h1234_5678_9000, 40'h00_0000_0220, 40'h00_0000_0320,
             40'h00_0000_0420, 40'h00_0000_0520, 64'h1, 2, 2, 0);
    run_walk("leaf invalid", 48'h0ABC_DEF0_1000, 40'h00_0000_0230, 40'h00_0000_0330,
             40'h00_0000_0430, 40'h00_0000_0530, 64'h0000_0123_4567_8006, 3, 1, 0);
    run_walk("start while busy", 48'h3000_0060_0000, 40'h00_0000_0240, 40'h00_0000_0340,
             40'h00_0000_0440, 40'h00_0000_0540, 64'h0000_00AB_CDEF_0003, 3, 2, 1);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule